// File: doc/BRIEF.md
# CRC-Checked Block Loader

The loader moves one block of 32-bit words from a flash-side read port into an on-chip destination memory and proves the copy twice. Each block in flash is followed by one word holding its expected CRC. The loader fetches that word first, then streams the data words across and folds each one into its own running CRC. The destination memory keeps an independent CRC over the words it was written and reports it when the block ends. Both values are compared with the expected one.

When either comparison fails, the loader records the failure in a small error log and starts the whole block again, up to a retry limit given with the command. When the retries are used up, it raises a fatal flag that stays set and stops until reset. A block that passes both checks ends with a one-cycle done pulse. Flash device timing is outside the block: the read port takes one request at a time and accepts the answer whenever it arrives.

Top module: `crc_block_loader`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, done, fatal, flashReq, dstWrEn and logValid are all low.
- R2: A start is taken only when the loader is idle, not fatal and cmdLen is not zero. With base B and length N the first flash read is at address B+N (the expected CRC), then B, B+1 ... B+N-1 in order. Only one read is in flight: flashReq is a one-cycle pulse and the next one comes only after the answer.
- R3: Each data word taken with flashRdValid is written to the destination the following cycle, unchanged, at word index 0, 1 ... N-1 of the block.
- R4: The CRC is CRC-32 with polynomial 0x04C11DB7, start value 0xFFFFFFFF, the word fed most significant bit first, one word per cycle, with no final inversion. The engine check passes when the CRC over the N data words equals the expected word.
- R5: After the last write the loader waits for dstCrcValid. The destination check passes when dstCrc equals the expected word.
- R6: When both checks pass, done is high for exactly one cycle, in the cycle after dstCrcValid is taken, and the loader is idle in the cycle after that.
- R7: Every failed attempt pushes one log entry: the block base, a failure field with bit 0 set when the engine check failed and bit 1 set when the destination check failed, and the attempt number (0 for the first try).
- R8: After a failed attempt whose number is below cmdRetryLimit, the loader re-reads the block from the expected CRC at B+N, with the writes starting again at index 0.
- R9: When the attempt whose number equals cmdRetryLimit fails, fatal rises in the next cycle and stays set until reset; while fatal, busy, done, flashReq and dstWrEn are low and starts are ignored.
- R10: The log holds 8 entries in arrival order; logValid shows that the head fields are meaningful and logPop removes the head. A push into a full log is dropped; a pop from an empty log does nothing.
- R11: flashRdValid and dstCrcValid have no effect when the loader is not waiting for them, and a start while busy does not change the running block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdStart | input | 1 | Start a block transfer |
| cmdBase | input | 16 | Flash address of the first data word |
| cmdLen | input | 8 | Number of data words in the block |
| cmdRetryLimit | input | 3 | Number of reloads allowed (3 is the usual setting) |
| flashReq | output | 1 | Flash read request pulse |
| flashAddr | output | 16 | Flash word address of the request |
| flashRdValid | input | 1 | Flash read answer valid |
| flashRdData | input | 32 | Flash read answer word |
| dstWrEn | output | 1 | Destination write enable |
| dstWrAddr | output | 8 | Destination word index |
| dstWrData | output | 32 | Destination write word |
| dstCrcValid | input | 1 | Destination reports its CRC |
| dstCrc | input | 32 | CRC computed by the destination over its writes |
| busy | output | 1 | A block is in progress |
| done | output | 1 | Block passed both checks (one cycle) |
| fatal | output | 1 | Retries exhausted, loader halted |
| logValid | output | 1 | Error log is not empty |
| logPop | input | 1 | Remove the head log entry |
| logBase | output | 16 | Head entry: block base |
| logPoint | output | 2 | Head entry: bit 0 engine failed, bit 1 destination failed |
| logRetry | output | 3 | Head entry: attempt number |

## Verification
A flash request is visible the cycle after the start or the answer that leads to it, a destination write one cycle after its data word is taken, done one cycle after dstCrcValid is taken, fatal two cycles after it, and a new log head one cycle after the push or pop. The bench drives every input on the falling edge and reads every output on the falling edge, so each of these results is read exactly at the falling edge that follows the rising edge where it is due. The responding flash and destination models run inside the same per-cycle loop, which checks every request address and every write as it appears and checks the done or fatal outcome at the precise falling edge after the destination CRC is handed over.

// File: rtl/crc_loader_pkg.sv
package crc_loader_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_EXP,
    ST_WAIT_EXP,
    ST_REQ_DAT,
    ST_WAIT_DAT,
    ST_WAIT_DST,
    ST_CHECK,
    ST_HALT
  } loaderState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchCmd;   // capture base, length, retry limit
    logic loadExp;    // take expected CRC, restart engine CRC and index
    logic stepCrc;    // take one data word
    logic capDst;     // take destination CRC
    logic pushLog;    // record failed attempt
    logic bumpRetry;  // next attempt
  } loaderStrb_t;

  // One 32-bit word folded into the CRC, most significant bit first
  function automatic logic [31:0] crcStep(input logic [31:0] crcIn,
                                          input logic [31:0] word);
    logic [31:0] r;
    r = crcIn ^ word;
    for (int i = 0; i < 32; i++) begin
      r = r[31] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_loader_errlog.sv
module crc_loader_errlog #(
  parameter int AW    = 16,
  parameter int RW    = 3,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [AW-1:0] pushBase,
  input  logic [1:0]    pushPoint,
  input  logic [RW-1:0] pushRetry,
  input  logic          pop,
  output logic          headValid,
  output logic [AW-1:0] headBase,
  output logic [1:0]    headPoint,
  output logic [RW-1:0] headRetry
);

  localparam int PW = $clog2(DEPTH);
  localparam int EW = AW + 2 + RW;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [PW:0]   count;
  logic          full, doPush, doPop;

  assign full      = (count == (PW+1)'(DEPTH));
  assign headValid = (count != '0);
  assign doPush    = push && !full;
  assign doPop     = pop && headValid;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {pushBase, pushPoint, pushRetry};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PW'(1);
      if (doPop)  rdPtr <= rdPtr + PW'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + (PW+1)'(1);
        2'b01:   count <= count - (PW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  assign {headBase, headPoint, headRetry} = mem[rdPtr];

endmodule

// File: rtl/crc_loader_ctrl.sv
module crc_loader_ctrl
  import crc_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic        cmdLenNonZero,
  input  logic        flashRdValid,
  input  logic        dstCrcValid,
  input  logic        lastWord,
  input  logic        engOk,
  input  logic        dstOk,
  input  logic        atLimit,
  output loaderStrb_t strb,
  output logic        flashReq,
  output logic        selExpAddr,
  output logic        busy,
  output logic        done,
  output logic        fatal
);

  loaderState_e stateQ, stateD;

  always_comb begin
    stateD     = stateQ;
    strb       = '0;
    flashReq   = 1'b0;
    selExpAddr = 1'b0;
    done       = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (cmdStart && cmdLenNonZero) begin
          strb.latchCmd = 1'b1;
          stateD        = ST_REQ_EXP;
        end
      end
      ST_REQ_EXP: begin
        flashReq   = 1'b1;
        selExpAddr = 1'b1;
        stateD     = ST_WAIT_EXP;
      end
      ST_WAIT_EXP: begin
        if (flashRdValid) begin
          strb.loadExp = 1'b1;
          stateD       = ST_REQ_DAT;
        end
      end
      ST_REQ_DAT: begin
        flashReq = 1'b1;
        stateD   = ST_WAIT_DAT;
      end
      ST_WAIT_DAT: begin
        if (flashRdValid) begin
          strb.stepCrc = 1'b1;
          stateD       = lastWord ? ST_WAIT_DST : ST_REQ_DAT;
        end
      end
      ST_WAIT_DST: begin
        if (dstCrcValid) begin
          strb.capDst = 1'b1;
          stateD      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (engOk && dstOk) begin
          done   = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strb.pushLog = 1'b1;
          if (atLimit) begin
            stateD = ST_HALT;
          end else begin
            strb.bumpRetry = 1'b1;
            stateD         = ST_REQ_EXP;
          end
        end
      end
      default: stateD = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy  = (stateQ != ST_IDLE) && (stateQ != ST_HALT);
  assign fatal = (stateQ == ST_HALT);

endmodule

// File: rtl/crc_loader_dpath.sv
module crc_loader_dpath
  import crc_loader_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LW        = 8,
  parameter int RW        = 3,
  parameter int LOG_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  loaderStrb_t   strb,
  input  logic          selExpAddr,
  input  logic [AW-1:0] cmdBase,
  input  logic [LW-1:0] cmdLen,
  input  logic [RW-1:0] cmdRetryLimit,
  input  logic [31:0]   flashRdData,
  input  logic [31:0]   dstCrc,
  output logic [AW-1:0] flashAddr,
  output logic          dstWrEn,
  output logic [LW-1:0] dstWrAddr,
  output logic [31:0]   dstWrData,
  output logic          lastWord,
  output logic          engOk,
  output logic          dstOk,
  output logic          atLimit,
  input  logic          logPop,
  output logic          logValid,
  output logic [AW-1:0] logBase,
  output logic [1:0]    logPoint,
  output logic [RW-1:0] logRetry
);

  logic [AW-1:0] baseQ;
  logic [LW-1:0] lenQ, idxQ, wrAddrQ;
  logic [RW-1:0] limitQ, retryQ;
  logic [31:0]   expQ, crcQ, dstQ, wrDataQ;
  logic          wrEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      lenQ    <= '0;
      limitQ  <= '0;
      retryQ  <= '0;
      idxQ    <= '0;
      expQ    <= '0;
      crcQ    <= '0;
      dstQ    <= '0;
      wrEnQ   <= 1'b0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
    end else begin
      wrEnQ <= strb.stepCrc;
      if (strb.latchCmd) begin
        baseQ  <= cmdBase;
        lenQ   <= cmdLen;
        limitQ <= cmdRetryLimit;
        retryQ <= '0;
      end
      if (strb.bumpRetry) retryQ <= retryQ + RW'(1);
      if (strb.loadExp) begin
        expQ <= flashRdData;
        crcQ <= CRC_INIT;
        idxQ <= '0;
      end
      if (strb.stepCrc) begin
        crcQ    <= crcStep(crcQ, flashRdData);
        idxQ    <= idxQ + LW'(1);
        wrAddrQ <= idxQ;
        wrDataQ <= flashRdData;
      end
      if (strb.capDst) dstQ <= dstCrc;
    end
  end

  assign flashAddr = selExpAddr ? (baseQ + AW'(lenQ)) : (baseQ + AW'(idxQ));
  assign dstWrEn   = wrEnQ;
  assign dstWrAddr = wrAddrQ;
  assign dstWrData = wrDataQ;
  assign lastWord  = (idxQ == lenQ - LW'(1));
  assign engOk     = (crcQ == expQ);
  assign dstOk     = (dstQ == expQ);
  assign atLimit   = (retryQ == limitQ);

  crc_loader_errlog #(
    .AW(AW), .RW(RW), .DEPTH(LOG_DEPTH)
  ) u_errlog (
    .clk       (clk),
    .rstN      (rstN),
    .push      (strb.pushLog),
    .pushBase  (baseQ),
    .pushPoint ({~dstOk, ~engOk}),
    .pushRetry (retryQ),
    .pop       (logPop),
    .headValid (logValid),
    .headBase  (logBase),
    .headPoint (logPoint),
    .headRetry (logRetry)
  );

endmodule

// File: rtl/crc_block_loader.sv
module crc_block_loader
  import crc_loader_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LW        = 8,
  parameter int RW        = 3,
  parameter int LOG_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdStart,
  input  logic [AW-1:0] cmdBase,
  input  logic [LW-1:0] cmdLen,
  input  logic [RW-1:0] cmdRetryLimit,
  output logic          flashReq,
  output logic [AW-1:0] flashAddr,
  input  logic          flashRdValid,
  input  logic [31:0]   flashRdData,
  output logic          dstWrEn,
  output logic [LW-1:0] dstWrAddr,
  output logic [31:0]   dstWrData,
  input  logic          dstCrcValid,
  input  logic [31:0]   dstCrc,
  output logic          busy,
  output logic          done,
  output logic          fatal,
  output logic          logValid,
  input  logic          logPop,
  output logic [AW-1:0] logBase,
  output logic [1:0]    logPoint,
  output logic [RW-1:0] logRetry
);

  loaderStrb_t strb;
  logic selExpAddr, lastWord, engOk, dstOk, atLimit;

  crc_loader_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cmdStart      (cmdStart),
    .cmdLenNonZero (cmdLen != '0),
    .flashRdValid  (flashRdValid),
    .dstCrcValid   (dstCrcValid),
    .lastWord      (lastWord),
    .engOk         (engOk),
    .dstOk         (dstOk),
    .atLimit       (atLimit),
    .strb          (strb),
    .flashReq      (flashReq),
    .selExpAddr    (selExpAddr),
    .busy          (busy),
    .done          (done),
    .fatal         (fatal)
  );

  crc_loader_dpath #(
    .AW(AW), .LW(LW), .RW(RW), .LOG_DEPTH(LOG_DEPTH)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .selExpAddr    (selExpAddr),
    .cmdBase       (cmdBase),
    .cmdLen        (cmdLen),
    .cmdRetryLimit (cmdRetryLimit),
    .flashRdData   (flashRdData),
    .dstCrc        (dstCrc),
    .flashAddr     (flashAddr),
    .dstWrEn       (dstWrEn),
    .dstWrAddr     (dstWrAddr),
    .dstWrData     (dstWrData),
    .lastWord      (lastWord),
    .engOk         (engOk),
    .dstOk         (dstOk),
    .atLimit       (atLimit),
    .logPop        (logPop),
    .logValid      (logValid),
    .logBase       (logBase),
    .logPoint      (logPoint),
    .logRetry      (logRetry)
  );

endmodule

// File: rtl/crc_loader_checker.sv
module crc_loader_checker (
  input logic clk,
  input logic rstN,
  input logic flashReq,
  input logic flashRdValid,
  input logic dstWrEn,
  input logic busy,
  input logic done,
  input logic fatal
);

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    flashReq |=> !flashReq); // R2

  AST_WRITE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    dstWrEn |-> $past(flashRdValid)); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R6

  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fatal |=> fatal); // R9

  AST_FATAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    fatal |-> (!busy && !done && !flashReq && !dstWrEn)); // R9

endmodule

bind crc_block_loader crc_loader_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .flashReq     (flashReq),
  .flashRdValid (flashRdValid),
  .dstWrEn      (dstWrEn),
  .busy         (busy),
  .done         (done),
  .fatal        (fatal)
);

// File: tb/crc_block_loader_bench.sv
module crc_block_loader_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic [15:0] cmdBase = '0;
  logic [7:0]  cmdLen = '0;
  logic [2:0]  cmdRetryLimit = '0;
  logic        flashReq;
  logic [15:0] flashAddr;
  logic        flashRdValid = 1'b0;
  logic [31:0] flashRdData = '0;
  logic        dstWrEn;
  logic [7:0]  dstWrAddr;
  logic [31:0] dstWrData;
  logic        dstCrcValid = 1'b0;
  logic [31:0] dstCrc = '0;
  logic        busy, done, fatal, logValid;
  logic        logPop = 1'b0;
  logic [15:0] logBase;
  logic [1:0]  logPoint;
  logic [2:0]  logRetry;

  int checks = 0;
  int failures = 0;

  // expected log contents, depth 8
  logic [15:0] eBase [8];
  logic [1:0]  ePoint [8];
  logic [2:0]  eRetry [8];
  int eHead = 0;
  int eCnt = 0;

  always #10 clk = ~clk;

  crc_block_loader u_crc_block_loader (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdBase(cmdBase),
    .cmdLen(cmdLen), .cmdRetryLimit(cmdRetryLimit), .flashReq(flashReq),
    .flashAddr(flashAddr), .flashRdValid(flashRdValid), .flashRdData(flashRdData),
    .dstWrEn(dstWrEn), .dstWrAddr(dstWrAddr), .dstWrData(dstWrData),
    .dstCrcValid(dstCrcValid), .dstCrc(dstCrc), .busy(busy), .done(done),
    .fatal(fatal), .logValid(logValid), .logPop(logPop), .logBase(logBase),
    .logPoint(logPoint), .logRetry(logRetry)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // bit-serial CRC-32 reference
  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [31:0] d);
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

  function automatic logic [31:0] fword(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [1:0] pointOf(input logic [1:0] kind);
    // kind 1: data corrupt (both fail), 2: destination only, 3: engine only
    case (kind)
      2'd1: return 2'b11;
      2'd2: return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  task automatic logPush(input logic [15:0] b, input logic [1:0] p, input logic [2:0] r);
    if (eCnt < 8) begin
      eBase[(eHead + eCnt) % 8]  = b;
      ePoint[(eHead + eCnt) % 8] = p;
      eRetry[(eHead + eCnt) % 8] = r;
      eCnt++;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fatal && !flashReq && !dstWrEn && !logValid,
        "R1 outputs low in reset", {busy, done, fatal, flashReq, dstWrEn, logValid}, 0);
    rstN = 1'b1;
    eHead = 0;
    eCnt  = 0;
    @(negedge clk);
    chk(!busy && !done && !fatal && !flashReq && !dstWrEn && !logValid,
        "R1 outputs low after reset", {busy, done, fatal, flashReq, dstWrEn, logValid}, 0);
  endtask

  task automatic drainLog();
    while (eCnt > 0) begin
      @(negedge clk);
      chk(logValid, "R10 log entry present", logValid, 1);
      chk(logBase == eBase[eHead], "R7 log base", logBase, eBase[eHead]);
      chk(logPoint == ePoint[eHead], "R7 log failure field", logPoint, ePoint[eHead]);
      chk(logRetry == eRetry[eHead], "R7 log attempt", logRetry, eRetry[eHead]);
      logPop = 1'b1;
      eHead = (eHead + 1) % 8;
      eCnt--;
      @(negedge clk);
      logPop = 1'b0;
    end
    @(negedge clk);
    chk(!logValid, "R10 log empty after drain", logValid, 0);
    logPop = 1'b1;
    @(negedge clk);
    logPop = 1'b0;
    chk(!logValid, "R10 pop on empty log", logValid, 0);
  endtask

  // kinds: 2 bits per attempt, 0 means the attempt is clean
  task automatic runXfer(input logic [15:0] base, input int len, input int limit,
                         input logic [15:0] kinds, input bit stray);
    logic [31:0] expCrc, dcrc, w, want;
    logic [15:0] pendAddr;
    logic [1:0]  kind;
    int attempt, cnt, reqPos, wrIdx, stage, cyc;
    bit finished, expectFatal;
    expCrc = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) expCrc = refCrc(expCrc, fword(base + 16'(i)));
    attempt = -1; cnt = 0; reqPos = 0; wrIdx = 0; stage = 0; cyc = 0;
    finished = 0; expectFatal = 0; dcrc = 32'hFFFF_FFFF; pendAddr = '0; kind = '0;
    @(negedge clk);
    cmdBase = base; cmdLen = 8'(len); cmdRetryLimit = 3'(limit); cmdStart = 1'b1;
    while (!finished && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      cmdStart = 1'b0;
      dstCrcValid = 1'b0;
      flashRdValid = 1'b0;
      // outcome of the attempt whose destination CRC was handed over last cycle
      if (stage == 1) begin
        chk(done == (kind == 2'd0), "R6 done after both checks", done, kind == 2'd0);
        if (kind == 2'd0) begin
          finished = 1;
        end else begin
          logPush(base, pointOf(kind), 3'(attempt));
          if (attempt == limit) begin
            stage = 2;
            expectFatal = 1;
          end else stage = 0;
        end
      end else if (stage == 2) begin
        chk(fatal, "R9 fatal after last retry fails", fatal, 1);
        finished = 1;
        stage = 0;
      end else if (done) begin
        chk(0, "R6 done at unexpected cycle", done, 0);
      end
      if (finished) break;
      // flash answer
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          flashRdValid = 1'b1;
          if (pendAddr == base + 16'(len)) flashRdData = expCrc;
          else begin
            w = fword(pendAddr);
            if (pendAddr == base && (kind == 2'd1 || kind == 2'd3)) w = w ^ 32'h1;
            flashRdData = w;
          end
        end
      end
      // flash request
      if (flashReq) begin
        if (reqPos == 0) begin
          attempt++;
          kind = kinds[2*attempt +: 2];
          chk(flashAddr == base + 16'(len), "R2 R8 expected-CRC read address", flashAddr, base + 16'(len));
        end else begin
          chk(flashAddr == base + 16'(reqPos - 1), "R2 data read address", flashAddr, base + 16'(reqPos - 1));
          if (stray && attempt == 0 && reqPos == 1) begin
            dstCrcValid = 1'b1;   // R11 not waiting for it
            dstCrc = 32'hDEAD_BEEF;
            cmdStart = 1'b1;      // R11 start while busy
            cmdBase = base + 16'h0100;
          end
        end
        reqPos = (reqPos == len) ? 0 : reqPos + 1;
        pendAddr = flashAddr;
        cnt = 1 + (cyc % 3);
      end
      // destination model
      if (dstWrEn) begin
        chk(dstWrAddr == 8'(wrIdx), "R3 write index", dstWrAddr, wrIdx);
        want = fword(base + 16'(wrIdx));
        if (wrIdx == 0 && (kind == 2'd1 || kind == 2'd3)) want = want ^ 32'h1;
        chk(dstWrData == want, "R3 write data", dstWrData, want);
        if (wrIdx == 0) dcrc = 32'hFFFF_FFFF;
        dcrc = refCrc(dcrc, dstWrData);
        wrIdx++;
        if (wrIdx == len) begin
          wrIdx = 0;
          dstCrcValid = 1'b1;
          if (kind == 2'd2) dstCrc = dcrc ^ 32'h8000_0000;
          else if (kind == 2'd3) dstCrc = expCrc;
          else dstCrc = dcrc;
          stage = 1;
        end
      end
    end
    if (!finished) chk(0, "R2 transfer did not finish", cyc, 4000);
    @(negedge clk);
    dstCrcValid = 1'b0;
    flashRdValid = 1'b0;
    cmdStart = 1'b0;
    chk(!busy, "R6 R9 idle or halted after outcome", busy, 0);
    chk(fatal == expectFatal, "R9 fatal state", fatal, expectFatal);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2 run did not end actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();

    // R11: stray answers while idle
    @(negedge clk);
    flashRdValid = 1'b1; flashRdData = 32'h1234_5678;
    dstCrcValid = 1'b1; dstCrc = 32'h0;
    @(negedge clk);
    flashRdValid = 1'b0; dstCrcValid = 1'b0;
    chk(!busy && !dstWrEn && !done && !logValid, "R11 stray inputs while idle",
        {busy, dstWrEn, done, logValid}, 0);

    // R2: zero length start ignored
    @(negedge clk);
    cmdBase = 16'h0040; cmdLen = 8'd0; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    chk(!busy && !flashReq, "R2 zero length start ignored", {busy, flashReq}, 0);

    // R4 R5 R6 R7 R8: sweep lengths and first-attempt fault kinds
    for (int len = 1; len <= 5; len++) begin
      for (int k = 0; k < 4; k++) begin
        runXfer(16'(16'h0200 + 32 * len + k), len, 3, 16'(k), (len == 3));
        drainLog();
      end
    end

    // R8: several failures, each kind, then success on the last allowed attempt
    runXfer(16'h0500, 4, 3, 16'b00_11_10_01, 1'b0);
    drainLog();

    // R9: no retries allowed
    runXfer(16'h0600, 2, 0, 16'b01, 1'b0);
    drainLog();
    @(negedge clk);
    cmdBase = 16'h0700; cmdLen = 8'd2; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(fatal && !busy && !flashReq, "R9 start ignored while fatal", {fatal, busy, flashReq}, 3'b100);
    end
    doReset();

    // R9: default limit of 3, every attempt fails at the destination
    runXfer(16'h0800, 3, 3, 16'hAAAA, 1'b0);
    drainLog();
    doReset();

    // R10: overflow, 3 entries then 8 more without popping
    runXfer(16'h0900, 2, 3, 16'b00_11_10_01, 1'b0);
    runXfer(16'h0A00, 1, 7, 16'h5555, 1'b0);
    chk(eCnt == 8, "R10 model holds 8 entries", eCnt, 8);
    drainLog();
    doReset();

    // after reset a clean block works again
    runXfer(16'h0B00, 5, 3, 16'h0, 1'b0);
    drainLog();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule